// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard and Redirect Control

This block is the hazard and steering logic for a three-stage 32-bit RISC-V integer pipeline. Stage 1 decodes an instruction and reads the register file. Stage 2 compares branch operands and runs the ALU. Stage 3 formats memory results, writes the register file back and chooses the next fetch address. The block looks at the instruction word held in each stage, the branch comparator's verdict and the low address bits of the stage-2 store. From these it drives the datapath's steering: one forwarding select per ALU operand, a fetch flush that puts a NOP in place of the word entering stage 1, a kill that sends a bubble into stage 2, the next-PC select code and the per-byte store enable.

All outputs are purely combinational from the current inputs. The ALU-to-ALU case and the load-to-ALU case share a single select per operand, because both results reach the stage-3 writeback value. Unconditional direct jumps get their target from a dedicated adder in stage 1, so they redirect one cycle earlier than branches and indirect jumps, which resolve in stage 2. The register file is assumed to write before it reads, so stage 1 always sees the value being retired in stage 3.

Top module: `hzd_ctrl3`

## Requirements
- R1: While `rst_n` is low, `pc_sel` is 3 (reset vector), `flush_fetch` and `kill_s1` are 1 and `st_mask` is 0, whatever the other inputs are.
- R2: `fwd_sel_a` is 1 (stage-3 writeback value) when the stage-3 instruction writes a register, its rd (bits 11:7) is not x0, the stage-2 instruction reads rs1 (bits 19:15) and the two indices match. Otherwise it is 0 (register file).
- R3: `fwd_sel_b` applies the same rule to rs2 (bits 24:20). Only branches, stores and register-register ALU operations read rs2.
- R4: An operand never forwards from rd = x0, and never from a stage-3 store or branch, whatever its bits 11:7 hold.
- R5: A stage-3 load forwards through the same select as an ALU result. Jumps that link, LUI and AUIPC also count as writers.
- R6: When stage 2 holds a JALR, or a conditional branch with `s2_br_taken` = 1, `pc_sel` is 1, and `flush_fetch` and `kill_s1` are both 1. These are two flushed slots.
- R7: A stage-2 branch with `s2_br_taken` = 0 causes no redirect and no flush. `s2_br_taken` has no effect unless stage 2 holds a conditional branch.
- R8: A JAL in stage 1, with no stage-2 redirect, gives `pc_sel` = 2, `flush_fetch` = 1 and `kill_s1` = 0. This is one flushed slot.
- R9: A stage-2 redirect takes priority over a stage-1 JAL (`pc_sel` = 1). Reset takes priority over both.
- R10: For a stage-2 store, `st_mask` bit i enables byte i. SB (funct3 000) sets bit `s2_addr_lo`. SH (funct3 001) sets bits {a1,0} and {a1,1}, where a1 is address bit 1. SW (funct3 010) sets all four bits.
- R11: `st_mask` is 0 when stage 2 holds a non-store or a store whose funct3 is not 000, 001 or 010.
- R12: With reset released, no stage-2 redirect and no stage-1 JAL, `pc_sel` is 0 (PC+4) and both flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset; forces the reset-vector select |
| inst_s1 | input | 32 | Instruction word in stage 1 |
| inst_s2 | input | 32 | Instruction word in stage 2 |
| inst_s3 | input | 32 | Instruction word in stage 3 |
| s2_br_taken | input | 1 | Branch comparator verdict for the stage-2 instruction |
| s2_addr_lo | input | 2 | Low byte-address bits of the stage-2 memory access |
| fwd_sel_a | output | 1 | ALU operand A source: 0 register file, 1 stage-3 writeback |
| fwd_sel_b | output | 1 | ALU operand B / store data source, same coding |
| flush_fetch | output | 1 | Replace the word entering stage 1 with a NOP |
| kill_s1 | output | 1 | Replace the stage-1 word entering stage 2 with a NOP |
| pc_sel | output | 2 | 0 PC+4, 1 stage-2 target, 2 stage-1 JAL target, 3 reset vector |
| st_mask | output | 4 | Per-byte store write enable |

## Verification
The bench builds the block at its default 32-bit data width, which gives a four-bit store mask and a two-bit byte offset. At that width every byte lane and halfword position can be reached: all four SB offsets, both SH halves including an odd address, and the full word. The too-wide doubleword store encoding lands on the rejected-size path. Instruction words are assembled in the bench from field values. This makes it possible to aim rd-field bits of stores and branches at live source registers, and to place a stage-1 JAL behind a stage-2 jump, so the priority path is exercised.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int ILEN  = 32;
  localparam int REG_W = 5;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;

  typedef enum logic [1:0] {
    PCS_SEQ   = 2'd0,
    PCS_EXEC  = 2'd1,
    PCS_JUMP1 = 2'd2,
    PCS_BOOT  = 2'd3
  } pcsel_e;

  function automatic logic [6:0] opc_of(input logic [ILEN-1:0] w);
    return w[6:0];
  endfunction

  function automatic logic [REG_W-1:0] rd_of(input logic [ILEN-1:0] w);
    return w[11:7];
  endfunction

  function automatic logic [REG_W-1:0] rs1_of(input logic [ILEN-1:0] w);
    return w[19:15];
  endfunction

  function automatic logic [REG_W-1:0] rs2_of(input logic [ILEN-1:0] w);
    return w[24:20];
  endfunction

  function automatic logic [2:0] f3_of(input logic [ILEN-1:0] w);
    return w[14:12];
  endfunction

  function automatic logic writes_rd(input logic [ILEN-1:0] w);
    case (opc_of(w))
      OPC_LUI, OPC_AUIPC, OPC_JAL, OPC_JALR,
      OPC_LOAD, OPC_OPIMM, OPC_OP: return 1'b1;
      default:                     return 1'b0;
    endcase
  endfunction

  function automatic logic reads_rs1(input logic [ILEN-1:0] w);
    case (opc_of(w))
      OPC_JALR, OPC_BRANCH, OPC_LOAD,
      OPC_STORE, OPC_OPIMM, OPC_OP: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic reads_rs2(input logic [ILEN-1:0] w);
    case (opc_of(w))
      OPC_BRANCH, OPC_STORE, OPC_OP: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hc_fwd.sv
module hc_fwd
  import hc_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic [ILEN-1:0]    inst_use,
  input  logic [ILEN-1:0]    inst_wb,
  output logic [NUM_SRC-1:0] sel
);
  logic [REG_W-1:0] wb_rd;
  logic             wb_live;

  assign wb_rd   = rd_of(inst_wb);
  assign wb_live = writes_rd(inst_wb) && (wb_rd != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [REG_W-1:0] src_idx;
    logic             src_used;
    if (g == 0) begin : g_rs1
      assign src_idx  = rs1_of(inst_use);
      assign src_used = reads_rs1(inst_use);
    end else begin : g_rs2
      assign src_idx  = rs2_of(inst_use);
      assign src_used = reads_rs2(inst_use);
    end
    assign sel[g] = src_used && wb_live && (src_idx == wb_rd);
  end
endmodule

// File: rtl/hc_redirect.sv
module hc_redirect
  import hc_pkg::*;
(
  input  logic            rst_n,
  input  logic [ILEN-1:0] inst_s1,
  input  logic [ILEN-1:0] inst_s2,
  input  logic            br_taken,
  output pcsel_e          pc_sel,
  output logic            flush_fetch,
  output logic            kill_s1
);
  logic s2_redir;
  logic s1_jal;

  assign s2_redir = (opc_of(inst_s2) == OPC_JALR) ||
                    ((opc_of(inst_s2) == OPC_BRANCH) && br_taken);
  assign s1_jal   = (opc_of(inst_s1) == OPC_JAL);

  always_comb begin
    pc_sel      = PCS_SEQ;
    flush_fetch = 1'b0;
    kill_s1     = 1'b0;
    if (!rst_n) begin
      pc_sel      = PCS_BOOT;
      flush_fetch = 1'b1;
      kill_s1     = 1'b1;
    end else if (s2_redir) begin
      pc_sel      = PCS_EXEC;
      flush_fetch = 1'b1;
      kill_s1     = 1'b1;
    end else if (s1_jal) begin
      pc_sel      = PCS_JUMP1;
      flush_fetch = 1'b1;
    end
  end
endmodule

// File: rtl/hc_store_mask.sv
module hc_store_mask
  import hc_pkg::*;
#(
  parameter  int MASK_W = 4,
  localparam int ADDR_W = $clog2(MASK_W)
) (
  input  logic [ILEN-1:0]   inst,
  input  logic [ADDR_W-1:0] addr_lo,
  output logic [MASK_W-1:0] mask
);
  always_comb begin
    int nbytes;
    int base;
    mask   = '0;
    nbytes = 1 << int'(f3_of(inst)[1:0]);
    base   = int'(addr_lo) & ~(nbytes - 1);
    if ((opc_of(inst) == OPC_STORE) && !f3_of(inst)[2] && (nbytes <= MASK_W)) begin
      for (int i = 0; i < MASK_W; i++) begin
        if ((i >= base) && (i < base + nbytes)) mask[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hzd_ctrl3.sv
module hzd_ctrl3
  import hc_pkg::*;
#(
  parameter  int XLEN   = 32,
  localparam int MASK_W = XLEN / 8,
  localparam int ADDR_W = $clog2(MASK_W)
) (
  input  logic              rst_n,
  input  logic [ILEN-1:0]   inst_s1,
  input  logic [ILEN-1:0]   inst_s2,
  input  logic [ILEN-1:0]   inst_s3,
  input  logic              s2_br_taken,
  input  logic [ADDR_W-1:0] s2_addr_lo,
  output logic              fwd_sel_a,
  output logic              fwd_sel_b,
  output logic              flush_fetch,
  output logic              kill_s1,
  output logic [1:0]        pc_sel,
  output logic [MASK_W-1:0] st_mask
);
  logic [1:0]        fwd_vec;
  pcsel_e            pc_sel_e;
  logic [MASK_W-1:0] mask_raw;

  hc_fwd #(.NUM_SRC(2)) u_fwd (
    .inst_use (inst_s2),
    .inst_wb  (inst_s3),
    .sel      (fwd_vec)
  );

  hc_redirect u_redirect (
    .rst_n       (rst_n),
    .inst_s1     (inst_s1),
    .inst_s2     (inst_s2),
    .br_taken    (s2_br_taken),
    .pc_sel      (pc_sel_e),
    .flush_fetch (flush_fetch),
    .kill_s1     (kill_s1)
  );

  hc_store_mask #(.MASK_W(MASK_W)) u_mask (
    .inst    (inst_s2),
    .addr_lo (s2_addr_lo),
    .mask    (mask_raw)
  );

  assign fwd_sel_a = fwd_vec[0];
  assign fwd_sel_b = fwd_vec[1];
  assign pc_sel    = pc_sel_e;
  assign st_mask   = rst_n ? mask_raw : '0;
endmodule

// File: rtl/hzd_ctrl3_chk.sv
module hzd_ctrl3_chk #(
  parameter int MASK_W = 4
) (
  input logic              rst_n,
  input logic [4:0]        s3_rd,
  input logic [4:0]        s2_rs1,
  input logic [4:0]        s2_rs2,
  input logic              fwd_sel_a,
  input logic              fwd_sel_b,
  input logic              flush_fetch,
  input logic              kill_s1,
  input logic [1:0]        pc_sel,
  input logic [MASK_W-1:0] st_mask
);
  always_comb begin
    if (!rst_n) begin
      p_boot_select_r1: assert (pc_sel == 2'd3 && flush_fetch && kill_s1 && st_mask == '0);
    end
    if (fwd_sel_a) begin
      p_fwd_a_match_r2: assert (s3_rd != 5'd0 && s3_rd == s2_rs1);
    end
    if (fwd_sel_b) begin
      p_fwd_b_match_r3: assert (s3_rd != 5'd0 && s3_rd == s2_rs2);
    end
    if (rst_n && kill_s1) begin
      p_two_slot_r6: assert (pc_sel == 2'd1 && flush_fetch);
    end
    if (pc_sel == 2'd2) begin
      p_one_slot_r8: assert (flush_fetch && !kill_s1);
    end
    p_mask_shape_r10: assert ($countones(st_mask) == 0 || $countones(st_mask) == 1 ||
                              $countones(st_mask) == 2 || $countones(st_mask) == MASK_W);
    if (rst_n && pc_sel == 2'd0) begin
      p_quiet_r12: assert (!flush_fetch && !kill_s1);
    end
  end
endmodule

bind hzd_ctrl3 hzd_ctrl3_chk #(.MASK_W(MASK_W)) u_chk (
  .rst_n       (rst_n),
  .s3_rd       (inst_s3[11:7]),
  .s2_rs1      (inst_s2[19:15]),
  .s2_rs2      (inst_s2[24:20]),
  .fwd_sel_a   (fwd_sel_a),
  .fwd_sel_b   (fwd_sel_b),
  .flush_fetch (flush_fetch),
  .kill_s1     (kill_s1),
  .pc_sel      (pc_sel),
  .st_mask     (st_mask)
);

// File: tb/hzd_ctrl3_tb.sv
module hzd_ctrl3_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] inst_s1, inst_s2, inst_s3;
  logic        s2_br_taken;
  logic [1:0]  s2_addr_lo;
  logic        fwd_sel_a, fwd_sel_b, flush_fetch, kill_s1;
  logic [1:0]  pc_sel;
  logic [3:0]  st_mask;

  int n_chk;
  int n_err;
  bit done;

  localparam logic [31:0] NOP = 32'h0000_0013;

  hzd_ctrl3 u_dut (
    .rst_n(rst_n), .inst_s1(inst_s1), .inst_s2(inst_s2), .inst_s3(inst_s3),
    .s2_br_taken(s2_br_taken), .s2_addr_lo(s2_addr_lo),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .flush_fetch(flush_fetch),
    .kill_s1(kill_s1), .pc_sel(pc_sel), .st_mask(st_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] e_r(input int rd, input int rs1, input int rs2);
    return {7'd0, rs2[4:0], rs1[4:0], 3'd0, rd[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input logic [6:0] opc, input int rd, input int rs1, input int imm);
    return {imm[11:0], rs1[4:0], 3'b010, rd[4:0], opc};
  endfunction
  function automatic logic [31:0] e_s(input int rs1, input int rs2, input int f3, input int lo);
    return {7'd0, rs2[4:0], rs1[4:0], f3[2:0], lo[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input int rs1, input int rs2, input int lo);
    return {7'd0, rs2[4:0], rs1[4:0], 3'd0, lo[4:0], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_jal(input int rd);
    return {20'h00010, rd[4:0], 7'b1101111};
  endfunction
  function automatic logic [31:0] e_jalr(input int rd, input int rs1);
    return {12'd0, rs1[4:0], 3'd0, rd[4:0], 7'b1100111};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic rn, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic tk, input logic [1:0] ad);
    @(negedge clk);
    rst_n = rn; inst_s1 = a; inst_s2 = b; inst_s3 = c; s2_br_taken = tk; s2_addr_lo = ad;
    #1;
  endtask

  task automatic t_reset;
    apply(1'b0, e_jal(1), e_s(2, 3, 2, 0), e_r(3, 1, 1), 1'b1, 2'd0);
    chk("R1 pc_sel", 32'(pc_sel), 32'd3);
    chk("R1 flush_fetch", 32'(flush_fetch), 32'd1);
    chk("R1 kill_s1", 32'(kill_s1), 32'd1);
    chk("R1 st_mask", 32'(st_mask), 32'd0);
  endtask

  task automatic t_fwd_alu;
    apply(1'b1, NOP, e_r(6, 5, 5), e_r(5, 1, 2), 1'b0, 2'd0);
    chk("R2 fwd a both", 32'(fwd_sel_a), 32'd1);
    chk("R3 fwd b both", 32'(fwd_sel_b), 32'd1);
    apply(1'b1, NOP, e_r(6, 7, 5), e_r(5, 1, 2), 1'b0, 2'd0);
    chk("R2 fwd a miss", 32'(fwd_sel_a), 32'd0);
    chk("R3 fwd b hit", 32'(fwd_sel_b), 32'd1);
    apply(1'b1, NOP, e_i(7'b0010011, 6, 5, 5), e_r(5, 1, 2), 1'b0, 2'd0);
    chk("R2 opimm a", 32'(fwd_sel_a), 32'd1);
    chk("R3 opimm no rs2", 32'(fwd_sel_b), 32'd0);
  endtask

  task automatic t_x0;
    apply(1'b1, NOP, e_r(6, 0, 0), e_r(0, 1, 2), 1'b0, 2'd0);
    chk("R4 x0 a", 32'(fwd_sel_a), 32'd0);
    chk("R4 x0 b", 32'(fwd_sel_b), 32'd0);
    apply(1'b1, NOP, e_r(7, 6, 6), e_s(1, 2, 2, 6), 1'b0, 2'd0);
    chk("R4 store not writer a", 32'(fwd_sel_a), 32'd0);
    chk("R4 store not writer b", 32'(fwd_sel_b), 32'd0);
    apply(1'b1, NOP, e_r(7, 6, 6), e_b(1, 2, 6), 1'b0, 2'd0);
    chk("R4 branch not writer", 32'(fwd_sel_a), 32'd0);
  endtask

  task automatic t_load;
    apply(1'b1, NOP, e_s(3, 9, 2, 0), e_i(7'b0000011, 9, 4, 0), 1'b0, 2'd0);
    chk("R5 load a", 32'(fwd_sel_a), 32'd0);
    chk("R5 load b", 32'(fwd_sel_b), 32'd1);
    apply(1'b1, NOP, e_r(2, 8, 3), e_i(7'b0110111, 8, 0, 0), 1'b0, 2'd0);
    chk("R5 lui writer", 32'(fwd_sel_a), 32'd1);
    apply(1'b1, NOP, e_b(1, 4, 0), e_jal(1), 1'b0, 2'd0);
    chk("R5 jal link writer", 32'(fwd_sel_a), 32'd1);
  endtask

  task automatic t_redirect;
    apply(1'b1, NOP, e_b(1, 2, 0), NOP, 1'b1, 2'd0);
    chk("R6 taken pc_sel", 32'(pc_sel), 32'd1);
    chk("R6 taken flush", 32'(flush_fetch), 32'd1);
    chk("R6 taken kill", 32'(kill_s1), 32'd1);
    apply(1'b1, NOP, e_jalr(1, 5), NOP, 1'b0, 2'd0);
    chk("R6 jalr pc_sel", 32'(pc_sel), 32'd1);
    chk("R6 jalr kill", 32'(kill_s1), 32'd1);
    apply(1'b1, NOP, e_b(1, 2, 0), NOP, 1'b0, 2'd0);
    chk("R7 not taken pc_sel", 32'(pc_sel), 32'd0);
    chk("R7 not taken flush", 32'(flush_fetch), 32'd0);
    apply(1'b1, NOP, e_r(3, 1, 2), NOP, 1'b1, 2'd0);
    chk("R7 taken flag ignored pc", 32'(pc_sel), 32'd0);
    chk("R7 taken flag ignored kill", 32'(kill_s1), 32'd0);
  endtask

  task automatic t_jal;
    apply(1'b1, e_jal(1), NOP, NOP, 1'b0, 2'd0);
    chk("R8 jal pc_sel", 32'(pc_sel), 32'd2);
    chk("R8 jal flush", 32'(flush_fetch), 32'd1);
    chk("R8 jal no kill", 32'(kill_s1), 32'd0);
    apply(1'b1, e_jal(1), e_jalr(0, 1), NOP, 1'b0, 2'd0);
    chk("R9 s2 beats jal", 32'(pc_sel), 32'd1);
    chk("R9 s2 beats jal kill", 32'(kill_s1), 32'd1);
    apply(1'b0, e_jal(1), e_b(1, 2, 0), NOP, 1'b1, 2'd0);
    chk("R9 reset beats all", 32'(pc_sel), 32'd3);
  endtask

  task automatic t_mask;
    for (int a = 0; a < 4; a++) begin
      apply(1'b1, NOP, e_s(1, 2, 0, 0), NOP, 1'b0, 2'(a));
      chk("R10 sb", 32'(st_mask), 32'(1 << a));
    end
    apply(1'b1, NOP, e_s(1, 2, 1, 0), NOP, 1'b0, 2'd0);
    chk("R10 sh low", 32'(st_mask), 32'h3);
    apply(1'b1, NOP, e_s(1, 2, 1, 0), NOP, 1'b0, 2'd1);
    chk("R10 sh odd low", 32'(st_mask), 32'h3);
    apply(1'b1, NOP, e_s(1, 2, 1, 0), NOP, 1'b0, 2'd3);
    chk("R10 sh high", 32'(st_mask), 32'hc);
    apply(1'b1, NOP, e_s(1, 2, 2, 0), NOP, 1'b0, 2'd2);
    chk("R10 sw", 32'(st_mask), 32'hf);
    apply(1'b1, NOP, e_i(7'b0000011, 3, 1, 0), NOP, 1'b0, 2'd0);
    chk("R11 load no mask", 32'(st_mask), 32'h0);
    apply(1'b1, NOP, e_s(1, 2, 3, 0), NOP, 1'b0, 2'd0);
    chk("R11 f3 011", 32'(st_mask), 32'h0);
    apply(1'b1, NOP, e_s(1, 2, 4, 0), NOP, 1'b0, 2'd0);
    chk("R11 f3 100", 32'(st_mask), 32'h0);
  endtask

  task automatic t_quiet;
    apply(1'b1, NOP, NOP, NOP, 1'b0, 2'd0);
    chk("R12 pc_sel", 32'(pc_sel), 32'd0);
    chk("R12 flush", 32'(flush_fetch), 32'd0);
    chk("R12 kill", 32'(kill_s1), 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; inst_s1 = NOP; inst_s2 = NOP; inst_s3 = NOP;
    s2_br_taken = 1'b0; s2_addr_lo = 2'd0;
    t_reset;
    t_quiet;
    t_fwd_alu;
    t_x0;
    t_load;
    t_redirect;
    t_jal;
    t_mask;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule